// File: doc/BRIEF.md
# Fowler exposure frame sequencer

This block decides which frame a large hybrid image sensor reads next during one exposure. After reset it holds an initialization phase. During that phase the pixel-clocking side clears its frame memory and loads the sensor's configuration over SPI. The sequencer waits for the acknowledge that ends this phase and then rests in Idle. A start command moves it into Exposure, where it issues frames one at a time. It emits a single-cycle frame-start pulse with a type tag and first/last-in-group flags, then waits for the pixel logic to report that the frame is complete.

An exposure runs in this order: a programmable number of reset frames, an optional reset-to-first-read delay counted in clock cycles, leading dropped frames, N pedestal reads, integration dropped frames, and N signal reads. Downstream logic uses the tags to accumulate the pedestal group and the signal group and to take their difference. N=1 gives plain correlated double sampling. A loop count repeats the whole series. An abort command ends the exposure at the next frame boundary.

Software programs the block through a plain write port. Values written while an exposure runs are held in staging registers. They are copied into a working set only when the next exposure starts.

Top module: `fowler_seq`

## Requirements
- R1: After reset `init_req` is high and `exposing` is low. A start command is ignored and no frame is issued until `init_ack` is seen high, after which `init_req` falls and the block rests in Idle.
- R2: Writes use addresses 0 to 6. Address 0 is the command register: bit 0 starts an exposure when in Idle, and bit 1 requests an abort. The other addresses hold the settings: 1 reset-frame count, 2 leading drop count, 3 read count N, 4 integration drop count, 5 delay in cycles, 6 extra-repeat count. `exposing` is high from the start command until the last frame of the exposure completes. `frame_start` is only ever high while `exposing` is high.
- R3: Frames are issued in this order: reset frames, leading drops, N pedestal reads, integration drops, N signal reads. The `frame_type` tag is 00 for reset, 01 for drop, 10 for pedestal read and 11 for signal read. A group whose count is zero is skipped.
- R4: `frame_first` is high on the first frame of each group and `frame_last` is high on the last one. Both flags, and `frame_type`, change only together with a `frame_start` pulse.
- R5: A read count of 0 is treated as 1. Read counts up to 255 are supported, which covers 30 Fowler pairs (60 reads).
- R6: When the reset count is nonzero and the delay D is nonzero, the first frame after the reset group starts exactly D clock cycles later than it would with D=0.
- R7: Setting writes made during an exposure do not change that exposure. They apply from the next start command.
- R8: With a repeat count L, the whole series runs L+1 times back to back, each pass beginning with its reset frames, before returning to Idle.
- R9: An abort requested during an exposure returns the block to Idle at the next frame completion, including an abort written in the same cycle as that completion. During the delay the return is immediate. No further frame is issued, and the next start runs normally.
- R10: `frame_start` is a single-cycle pulse. With no delay, the next frame starts in the cycle after `frame_done` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| init_ack | input | 1 | Initialization phase complete |
| frame_done | input | 1 | Current frame finished by the pixel logic |
| init_req | output | 1 | Initialization phase is in progress |
| exposing | output | 1 | An exposure is running |
| frame_start | output | 1 | One-cycle pulse: start the tagged frame |
| frame_type | output | 2 | Frame type tag |
| frame_first | output | 1 | Frame is first of its group |
| frame_last | output | 1 | Frame is last of its group |

## Verification
Two events can fall in the same cycle: a write to the command register carrying the abort bit, and the `frame_done` that closes a frame. The bench drives both on the same clock edge during a pedestal read. It then watches for thirty cycles and requires that no further frame starts and that `exposing` has dropped. A setting write also lands in the middle of a running exposure, and the bench requires the remaining frames to follow the counts that were in force at the start. Around these cases, the bench sweeps small reset, drop, read and delay counts. For each combination it derives the full tag, flag and timing sequence arithmetically.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  typedef enum logic [2:0] {
    PH_RST = 3'd0,
    PH_DRA = 3'd1,
    PH_PED = 3'd2,
    PH_DRB = 3'd3,
    PH_SIG = 3'd4
  } phase_e;

  typedef enum logic [2:0] {
    S_INIT   = 3'd0,
    S_IDLE   = 3'd1,
    S_LAUNCH = 3'd2,
    S_WAIT   = 3'd3,
    S_DELAY  = 3'd4
  } state_e;

  localparam int unsigned A_CTRL = 0;
  localparam int unsigned NFLD   = 6;   // settings at addresses 1..6
  localparam int unsigned F_NRST = 0;
  localparam int unsigned F_DRA  = 1;
  localparam int unsigned F_NRD  = 2;
  localparam int unsigned F_DRB  = 3;
  localparam int unsigned F_DLY  = 4;
  localparam int unsigned F_LOOP = 5;

  function automatic int unsigned fld_reset(int unsigned i);
    return (i == F_NRST || i == F_NRD) ? 1 : 0;
  endfunction

  function automatic logic [1:0] tag_of(phase_e p);
    case (p)
      PH_RST:         return 2'b00;
      PH_DRA, PH_DRB: return 2'b01;
      PH_PED:         return 2'b10;
      default:        return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/fsq_regs.sv
module fsq_regs
  import fsq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 8,
  parameter int DLY_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              go_p,
  output logic              abort_p,
  output logic [CNT_W-1:0]  st_nrst,
  output logic [CNT_W-1:0]  st_dra,
  output logic [CNT_W-1:0]  st_nrd,
  output logic [CNT_W-1:0]  st_drb,
  output logic [DLY_W-1:0]  st_dly,
  output logic [CNT_W-1:0]  st_loop
);

  logic ctrl_hit;
  assign ctrl_hit = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign go_p     = ctrl_hit && wr_data[0];
  assign abort_p  = ctrl_hit && wr_data[1];

  // One staging register per setting; the delay field is wider.
  for (genvar g = 0; g < int'(NFLD); g++) begin : g_fld
    localparam int FW = (g == int'(F_DLY)) ? DLY_W : CNT_W;
    logic [FW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= FW'(fld_reset(g));
      else if (wr_en && wr_addr == ADDR_W'(g + 1))
        q <= wr_data[FW-1:0];
    end
  end

  assign st_nrst = g_fld[0].q;
  assign st_dra  = g_fld[1].q;
  assign st_nrd  = g_fld[2].q;
  assign st_drb  = g_fld[3].q;
  assign st_dly  = g_fld[4].q;
  assign st_loop = g_fld[5].q;

endmodule

// File: rtl/fsq_cfg.sv
module fsq_cfg #(
  parameter int CNT_W = 8,
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] st_nrst,
  input  logic [CNT_W-1:0] st_dra,
  input  logic [CNT_W-1:0] st_nrd,
  input  logic [CNT_W-1:0] st_drb,
  input  logic [DLY_W-1:0] st_dly,
  input  logic [CNT_W-1:0] st_loop,
  output logic [CNT_W-1:0] w_nrst,
  output logic [CNT_W-1:0] w_dra,
  output logic [CNT_W-1:0] w_nrd,
  output logic [CNT_W-1:0] w_drb,
  output logic [DLY_W-1:0] w_dly,
  output logic [CNT_W-1:0] w_loop
);

  // Working copy, frozen for the whole exposure; a zero read count becomes one.
  always_ff @(posedge clk) begin
    if (rst) begin
      w_nrst <= CNT_W'(1);
      w_dra  <= '0;
      w_nrd  <= CNT_W'(1);
      w_drb  <= '0;
      w_dly  <= '0;
      w_loop <= '0;
    end else if (load) begin
      w_nrst <= st_nrst;
      w_dra  <= st_dra;
      w_nrd  <= (st_nrd == '0) ? CNT_W'(1) : st_nrd;
      w_drb  <= st_drb;
      w_dly  <= st_dly;
      w_loop <= st_loop;
    end
  end

endmodule

// File: rtl/fsq_core.sv
module fsq_core
  import fsq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_p,
  input  logic             abort_p,
  input  logic             init_ack,
  input  logic             frame_done,
  input  logic [CNT_W-1:0] w_nrst,
  input  logic [CNT_W-1:0] w_dra,
  input  logic [CNT_W-1:0] w_nrd,
  input  logic [CNT_W-1:0] w_drb,
  input  logic [DLY_W-1:0] w_dly,
  input  logic [CNT_W-1:0] w_loop,
  output logic             cfg_load,
  output logic             init_req,
  output logic             exposing,
  output logic             frame_start,
  output logic [1:0]       frame_type,
  output logic             frame_first,
  output logic             frame_last
);

  function automatic logic [CNT_W-1:0] cnt_sel(
    phase_e p, logic [CNT_W-1:0] nr, logic [CNT_W-1:0] da,
    logic [CNT_W-1:0] nd, logic [CNT_W-1:0] db);
    case (p)
      PH_RST:  return nr;
      PH_DRA:  return da;
      PH_DRB:  return db;
      default: return nd;
    endcase
  endfunction

  state_e           state, st_n;
  phase_e           phase, ph_n, hold_ph, hold_n, first_ph, nxt_ph, iss_ph;
  logic [CNT_W-1:0] idx, idx_n, iss_idx, cur_cnt, reps, reps_n;
  logic [DLY_W-1:0] dcnt, dcnt_n;
  logic             abort_q, abort_n, abort_now, iss, iss_last;

  assign exposing = (state == S_LAUNCH) || (state == S_WAIT) || (state == S_DELAY);
  assign init_req = (state == S_INIT);
  assign cfg_load = (state == S_IDLE) && go_p;

  assign cur_cnt  = cnt_sel(phase, w_nrst, w_dra, w_nrd, w_drb);
  assign first_ph = (w_nrst != '0) ? PH_RST : ((w_dra != '0) ? PH_DRA : PH_PED);

  always_comb begin
    case (phase)
      PH_RST:  nxt_ph = (w_dra != '0) ? PH_DRA : PH_PED;
      PH_DRA:  nxt_ph = PH_PED;
      PH_PED:  nxt_ph = (w_drb != '0) ? PH_DRB : PH_SIG;
      default: nxt_ph = PH_SIG;
    endcase
  end

  always_comb begin
    st_n      = state;
    ph_n      = phase;
    idx_n     = idx;
    dcnt_n    = dcnt;
    hold_n    = hold_ph;
    reps_n    = reps;
    abort_now = abort_q || abort_p;
    abort_n   = abort_q || (abort_p && exposing);
    iss       = 1'b0;
    iss_ph    = phase;
    iss_idx   = '0;
    case (state)
      S_INIT: if (init_ack) st_n = S_IDLE;
      S_IDLE: if (go_p) begin
        st_n   = S_LAUNCH;
        reps_n = '0;
      end
      S_LAUNCH: begin
        if (abort_now) st_n = S_IDLE;
        else begin
          iss    = 1'b1;
          iss_ph = first_ph;
        end
      end
      S_WAIT: if (frame_done) begin
        if (abort_now) begin
          st_n = S_IDLE;
        end else if (idx != cur_cnt - CNT_W'(1)) begin
          iss     = 1'b1;
          iss_ph  = phase;
          iss_idx = idx + CNT_W'(1);
        end else if (phase == PH_SIG) begin
          if (reps != w_loop) begin
            reps_n = reps + CNT_W'(1);
            st_n   = S_LAUNCH;
          end else begin
            st_n = S_IDLE;
          end
        end else if (phase == PH_RST && w_dly != '0) begin
          st_n   = S_DELAY;
          dcnt_n = w_dly;
          hold_n = nxt_ph;
        end else begin
          iss    = 1'b1;
          iss_ph = nxt_ph;
        end
      end
      S_DELAY: begin
        if (abort_now) st_n = S_IDLE;
        else if (dcnt == DLY_W'(1)) begin
          iss    = 1'b1;
          iss_ph = hold_ph;
        end else begin
          dcnt_n = dcnt - DLY_W'(1);
        end
      end
      default: st_n = S_IDLE;
    endcase
    if (iss) begin
      st_n  = S_WAIT;
      ph_n  = iss_ph;
      idx_n = iss_idx;
    end
    if (st_n == S_IDLE || st_n == S_INIT) abort_n = 1'b0;
  end

  assign iss_last = (iss_idx == cnt_sel(iss_ph, w_nrst, w_dra, w_nrd, w_drb) - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_INIT;
      phase       <= PH_RST;
      hold_ph     <= PH_RST;
      idx         <= '0;
      dcnt        <= '0;
      reps        <= '0;
      abort_q     <= 1'b0;
      frame_start <= 1'b0;
      frame_type  <= 2'b00;
      frame_first <= 1'b0;
      frame_last  <= 1'b0;
    end else begin
      state       <= st_n;
      phase       <= ph_n;
      hold_ph     <= hold_n;
      idx         <= idx_n;
      dcnt        <= dcnt_n;
      reps        <= reps_n;
      abort_q     <= abort_n;
      frame_start <= iss;
      if (iss) begin
        frame_type  <= tag_of(iss_ph);
        frame_first <= (iss_idx == '0);
        frame_last  <= iss_last;
      end
    end
  end

endmodule

// File: rtl/fowler_seq.sv
module fowler_seq #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 8,
  parameter int DLY_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              init_ack,
  input  logic              frame_done,
  output logic              init_req,
  output logic              exposing,
  output logic              frame_start,
  output logic [1:0]        frame_type,
  output logic              frame_first,
  output logic              frame_last
);

  logic             go_p, abort_p, cfg_load;
  logic [CNT_W-1:0] st_nrst, st_dra, st_nrd, st_drb, st_loop;
  logic [CNT_W-1:0] w_nrst, w_dra, w_nrd, w_drb, w_loop;
  logic [DLY_W-1:0] st_dly, w_dly;

  fsq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DLY_W(DLY_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .go_p(go_p), .abort_p(abort_p),
    .st_nrst(st_nrst), .st_dra(st_dra), .st_nrd(st_nrd), .st_drb(st_drb),
    .st_dly(st_dly), .st_loop(st_loop)
  );

  fsq_cfg #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_cfg (
    .clk(clk), .rst(rst), .load(cfg_load),
    .st_nrst(st_nrst), .st_dra(st_dra), .st_nrd(st_nrd), .st_drb(st_drb),
    .st_dly(st_dly), .st_loop(st_loop),
    .w_nrst(w_nrst), .w_dra(w_dra), .w_nrd(w_nrd), .w_drb(w_drb),
    .w_dly(w_dly), .w_loop(w_loop)
  );

  fsq_core #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_core (
    .clk(clk), .rst(rst), .go_p(go_p), .abort_p(abort_p),
    .init_ack(init_ack), .frame_done(frame_done),
    .w_nrst(w_nrst), .w_dra(w_dra), .w_nrd(w_nrd), .w_drb(w_drb),
    .w_dly(w_dly), .w_loop(w_loop),
    .cfg_load(cfg_load), .init_req(init_req), .exposing(exposing),
    .frame_start(frame_start), .frame_type(frame_type),
    .frame_first(frame_first), .frame_last(frame_last)
  );

endmodule

// File: rtl/fsq_chk.sv
module fsq_chk (
  input logic       clk,
  input logic       rst,
  input logic       init_req,
  input logic       exposing,
  input logic       frame_start,
  input logic [1:0] frame_type,
  input logic       frame_first,
  input logic       frame_last
);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  a_r2_start_in_exposure: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> exposing);

  a_r1_init_quiet: assert property (@(posedge clk) disable iff (rst)
    init_req |-> (!exposing && !frame_start));

  a_r4_type_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_start |-> $stable(frame_type));

  a_r4_flag_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_start |-> ($stable(frame_first) && $stable(frame_last)));

endmodule

bind fowler_seq fsq_chk u_chk (
  .clk(clk), .rst(rst), .init_req(init_req), .exposing(exposing),
  .frame_start(frame_start), .frame_type(frame_type),
  .frame_first(frame_first), .frame_last(frame_last)
);

// File: tb/fowler_seq_tb_top.sv
module fowler_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        init_ack = 1'b0;
  logic        frame_done = 1'b0;
  logic        init_req, exposing, frame_start, frame_first, frame_last;
  logic [1:0]  frame_type;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  fowler_seq dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .init_ack(init_ack), .frame_done(frame_done),
    .init_req(init_req), .exposing(exposing), .frame_start(frame_start),
    .frame_type(frame_type), .frame_first(frame_first), .frame_last(frame_last)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int tag(int ph);
    case (ph)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 1;
      default: return 3;
    endcase
  endfunction

  // mode: 0 plain, 1 abort together with done, 2 abort before done,
  //       3 abort after done, 4 settings write before done
  task automatic exp_frame(int ph, bit f, bit l, int gap, string greq, int mode, string treq);
    int cnt = 1;
    while (!frame_start && cnt < 3000) begin
      @(negedge clk);
      cnt++;
    end
    chk(frame_start == 1'b1, treq, "frame start seen", int'(frame_start), 1);
    chk(int'(frame_type) == tag(ph), treq, "frame type", int'(frame_type), tag(ph));
    chk(frame_first == f && frame_last == l, "R4", "first/last flags",
        int'({frame_first, frame_last}), int'({f, l}));
    chk(exposing == 1'b1, "R2", "exposing during frame", int'(exposing), 1);
    if (gap >= 0) chk(cnt == gap, greq, "cycles to frame start", cnt, gap);
    if (mode == 2) wr(0, 2);
    if (mode == 4) begin
      wr(3, 7); wr(1, 3); wr(5, 9);
    end
    @(negedge clk);
    frame_done = 1'b1;
    if (mode == 1) begin
      wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'd2;
    end
    @(negedge clk);
    frame_done = 1'b0;
    wr_en = 1'b0;
    if (mode == 3) wr(0, 2);
  endtask

  task automatic setup(int nr, int da, int n, int db, int dly, int lp);
    wr(1, nr); wr(2, da); wr(3, n); wr(4, db); wr(5, dly); wr(6, lp);
  endtask

  task automatic run_exp(int nr, int da, int n, int db, int dly, int lp, bit midwr, string treq);
    int ne = (n == 0) ? 1 : n;
    setup(nr, da, n, db, dly, lp);
    wr(0, 1);
    for (int rep = 0; rep <= lp; rep++) begin
      bit firstf = 1'b1;
      bit prev_rst = 1'b0;
      for (int ph = 0; ph < 5; ph++) begin
        int c = (ph == 0) ? nr : (ph == 1) ? da : (ph == 3) ? db : ne;
        for (int i = 0; i < c; i++) begin
          int gap = firstf ? -1 : ((prev_rst && ph != 0 && dly > 0) ? dly + 1 : 1);
          int mode = (midwr && rep == 0 && ph == 2 && i == 0) ? 4 : 0;
          exp_frame(ph, i == 0, i == c - 1, gap, (gap > 1) ? "R6" : "R10", mode, treq);
          firstf = 1'b0;
          prev_rst = (ph == 0);
        end
      end
    end
    chk(exposing == 1'b0, "R2", "exposing after last frame", int'(exposing), 0);
  endtask

  task automatic quiet(string req, int cycles);
    bit seen = 1'b0;
    repeat (cycles) begin
      @(negedge clk);
      if (frame_start) seen = 1'b1;
    end
    chk(!seen, req, "no frame start", int'(seen), 0);
    chk(exposing == 1'b0, req, "exposing low", int'(exposing), 0);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: initialization phase gates the start command
    chk(init_req == 1'b1, "R1", "init_req after reset", int'(init_req), 1);
    chk(exposing == 1'b0, "R1", "exposing after reset", int'(exposing), 0);
    chk(frame_start == 1'b0, "R10", "frame_start after reset", int'(frame_start), 0);
    wr(0, 1);
    quiet("R1", 12);
    @(negedge clk); init_ack = 1'b1;
    @(negedge clk); init_ack = 1'b0;
    chk(init_req == 1'b0, "R1", "init_req after ack", int'(init_req), 0);

    // R3/R6/R10 sweep over small counts
    for (int nr = 0; nr < 3; nr++)
      for (int da = 0; da < 2; da++)
        for (int n = 0; n < 3; n++)
          for (int db = 0; db < 3; db += 2)
            for (int dly = 0; dly < 4; dly += 3)
              run_exp(nr, da, (n == 2) ? 3 : n, db, dly, 0, 1'b0, (n == 0) ? "R5" : "R3");

    // R5: thirty Fowler pairs
    run_exp(1, 1, 30, 1, 2, 0, 1'b0, "R5");
    // R8: repeated series
    run_exp(2, 1, 2, 1, 4, 2, 1'b0, "R8");
    // R7: writes during exposure apply from the next start only
    run_exp(1, 0, 2, 1, 0, 0, 1'b1, "R7");
    wr(0, 1);
    for (int i = 0; i < 3; i++) exp_frame(0, i == 0, i == 2, (i == 0) ? -1 : 1, "R10", 0, "R7");
    for (int i = 0; i < 7; i++) exp_frame(2, i == 0, i == 6, (i == 0) ? 10 : 1, "R7", 0, "R7");
    exp_frame(1, 1'b1, 1'b1, 1, "R10", 0, "R7");
    for (int i = 0; i < 7; i++) exp_frame(4, i == 0, i == 6, 1, "R10", 0, "R7");
    chk(exposing == 1'b0, "R7", "exposing after new-config run", int'(exposing), 0);

    // R9: abort written before a frame completes
    setup(1, 0, 3, 0, 0, 0);
    wr(0, 1);
    exp_frame(0, 1'b1, 1'b1, -1, "R10", 0, "R9");
    exp_frame(2, 1'b1, 1'b0, 1, "R10", 2, "R9");
    quiet("R9", 30);
    // R9: abort in the same cycle as frame completion
    wr(0, 1);
    exp_frame(0, 1'b1, 1'b1, -1, "R10", 0, "R9");
    exp_frame(2, 1'b1, 1'b0, 1, "R10", 0, "R9");
    exp_frame(2, 1'b0, 1'b0, 1, "R10", 1, "R9");
    quiet("R9", 30);
    // R9: abort during the reset-to-read delay
    setup(1, 0, 3, 0, 20, 0);
    wr(0, 1);
    exp_frame(0, 1'b1, 1'b1, -1, "R10", 3, "R9");
    quiet("R9", 40);
    // R9: a normal run follows an abort
    run_exp(1, 0, 1, 0, 0, 0, 1'b0, "R9");

    summary();
    $finish;
  end

endmodule